// File: doc/BRIEF.md
# Strided Tile Row Loader With Resume

This block fills a two-dimensional register tile from memory, one row per memory request. A start command gives a base address, a displacement, an index value, a two-bit scale and an index-present flag. It also gives the number of rows to load, the number of bytes per row and a row at which to begin. The first row sits at base plus displacement. Each following row is one stride further on, and the stride is the index shifted left by the scale.

Requests leave on a valid/ready port with one request outstanding at a time. Each response carries either a row of data or a fault. A fault stops the load at once and reports the faulting row on `resumeRow`. Issuing the same command again with that row as the start row completes the tile without fetching the rows already loaded. A load that completes reports row zero, ready to be used as the start row of the next fresh load.

The tile can be read at any time through a combinational row read port.

Top module: `tile_row_loader`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `memReqValid` are 0, `resumeRow` is 0, and every tile row reads as zero.
- R2: An accepted start fetches rows beginning at `savedRow`, not at row 0. Tile rows below `savedRow` keep their previous contents.
- R3: The request for row r carries the address (baseAddr + dispAddr + r * (indexVal << scaleSel)) modulo 2^32. `memReqBytes` equals `rowBytes`.
- R4: When `indexPresent` is 0, the stride is zero, whatever `indexVal` holds, so every row request uses base plus displacement.
- R5: In the tile, byte k of a row occupies bits [8k+7:8k] and is taken from the same bits of `memRspData`. Bytes at k >= `rowBytes` are stored as zero.
- R6: Rows are requested in increasing order up to `rowCount`-1, one request outstanding. A request that is not accepted keeps `memReqValid` high.
- R7: After the last row is written, `done` pulses for one cycle with `resumeRow` = 0, and `busy` is low in that cycle.
- R8: A fault response ends the load. `fault` pulses for one cycle with `resumeRow` equal to the faulting row, and no further request is issued. The faulting row keeps its previous contents. `done` and `fault` are never high together.
- R9: On an accepted start, tile rows at or above `rowCount` are cleared, and they read as zero until the next start.
- R10: A start while `busy` is high is ignored, and the running load continues with its original parameters.
- R11: If `savedRow` >= `rowCount`, no request is issued, and `done` pulses in the cycle after the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start command strobe, accepted when not busy |
| baseAddr | input | 32 | Base address |
| dispAddr | input | 32 | Displacement added to the base (two's complement) |
| indexVal | input | 32 | Index value used to form the stride |
| scaleSel | input | 2 | Left shift applied to the index |
| indexPresent | input | 1 | 0: index treated as zero |
| rowCount | input | 5 | Configured number of rows (0..16) |
| rowBytes | input | 7 | Bytes per row (0..64) |
| savedRow | input | 5 | Row at which loading begins |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| resumeRow | output | 5 | Row to restart from (0 after completion) |
| memReqValid | output | 1 | Row read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Row start address |
| memReqBytes | output | 7 | Bytes requested |
| memRspValid | input | 1 | Response valid |
| memRspFault | input | 1 | Response reports a fault |
| memRspData | input | 512 | Row data, byte k in bits [8k+7:8k] |
| readRow | input | 4 | Tile row to read |
| readData | output | 512 | Contents of the selected row |

## Verification
The assertions check the following on every cycle. Completion and fault pulses never coincide, and completion always reports resume row zero. An unaccepted request stays valid. The row counter stays below the configured count while busy, so no write can land in the cleared upper rows. A start arriving while busy leaves the latched configuration untouched. An empty range finishes at once. The requested byte count never exceeds the row width. Only the bench's scenarios can show that the addresses follow base, displacement and shifted index, that padding bytes are zeroed, and that rows below the start row survive. They also show that a fault followed by a restart from the reported row leaves the same tile contents as an uninterrupted load.

// File: rtl/tile_loader_pkg.sv
package tile_loader_pkg;

  typedef struct packed {
    logic loadCfg;
    logic clearUpper;
    logic writeRow;
  } loaderStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } loaderState_t;

endpackage

// File: rtl/tile_loader_ctrl.sv
module tile_loader_ctrl
  import tile_loader_pkg::*;
#(
  parameter int ROWS = 16,
  localparam int CNT_W = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [CNT_W-1:0] rowCount,
  input  logic [CNT_W-1:0] savedRow,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic             memRspFault,
  output loaderStrobe_t    strobe,
  output logic [CNT_W-1:0] curRow,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [CNT_W-1:0] resumeRow,
  output logic             memReqValid
);

  loaderState_t     state;
  logic [CNT_W-1:0] rowLimit;
  logic [CNT_W-1:0] effCount;
  logic [CNT_W:0]   nextRow;
  logic             startAcc;

  assign effCount = (rowCount > CNT_W'(ROWS)) ? CNT_W'(ROWS) : rowCount;
  assign startAcc = (state == ST_IDLE) && startValid;
  assign nextRow  = {1'b0, curRow} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      curRow    <= '0;
      rowLimit  <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      resumeRow <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startValid) begin
            rowLimit <= effCount;
            curRow   <= savedRow;
            if (savedRow < effCount) begin
              state <= ST_REQ;
            end else begin
              done      <= 1'b1;
              resumeRow <= '0;
            end
          end
        end
        ST_REQ: begin
          if (memReqReady) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (memRspValid) begin
            if (memRspFault) begin
              fault     <= 1'b1;
              resumeRow <= curRow;
              state     <= ST_IDLE;
            end else if (nextRow >= {1'b0, rowLimit}) begin
              done      <= 1'b1;
              resumeRow <= '0;
              state     <= ST_IDLE;
            end else begin
              curRow <= nextRow[CNT_W-1:0];
              state  <= ST_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadCfg    = startAcc;
    strobe.clearUpper = startAcc;
    strobe.writeRow   = (state == ST_WAIT) && memRspValid && !memRspFault;
  end

  assign memReqValid = (state == ST_REQ);
  assign busy        = (state != ST_IDLE);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fault)); // R8
  AST_DONE_RESUME_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (resumeRow == '0) && !busy); // R7
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !busy && !memReqValid); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid); // R6
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (curRow < rowLimit)); // R6
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startValid) |=> $stable(rowLimit)); // R10
  AST_EMPTY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (startAcc && (savedRow >= effCount)) |=> done && !busy); // R11

endmodule

// File: rtl/tile_loader_dp.sv
module tile_loader_dp
  import tile_loader_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 64,
  parameter int ADDR_W    = 32,
  localparam int CNT_W      = $clog2(ROWS + 1),
  localparam int ROW_W      = $clog2(ROWS),
  localparam int BYTE_CNT_W = $clog2(ROW_BYTES + 1),
  localparam int DATA_W     = ROW_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  loaderStrobe_t         strobe,
  input  logic [CNT_W-1:0]      curRow,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [ADDR_W-1:0]     dispAddr,
  input  logic [ADDR_W-1:0]     indexVal,
  input  logic [1:0]            scaleSel,
  input  logic                  indexPresent,
  input  logic [CNT_W-1:0]      rowCount,
  input  logic [BYTE_CNT_W-1:0] rowBytes,
  input  logic [DATA_W-1:0]     memRspData,
  input  logic [ROW_W-1:0]      readRow,
  output logic [ADDR_W-1:0]     memReqAddr,
  output logic [BYTE_CNT_W-1:0] memReqBytes,
  output logic [DATA_W-1:0]     readData
);

  logic [ADDR_W-1:0]     firstAddr;
  logic [ADDR_W-1:0]     strideReg;
  logic [BYTE_CNT_W-1:0] bytesReg;
  logic [CNT_W-1:0]      countReg;
  logic [CNT_W-1:0]      countIn;
  logic [DATA_W-1:0]     byteMask;
  logic [DATA_W-1:0]     tile [ROWS];

  assign countIn = (rowCount > CNT_W'(ROWS)) ? CNT_W'(ROWS) : rowCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstAddr <= '0;
      strideReg <= '0;
      bytesReg  <= '0;
      countReg  <= '0;
    end else if (strobe.loadCfg) begin
      firstAddr <= baseAddr + dispAddr;
      strideReg <= indexPresent ? (indexVal << scaleSel) : '0;
      bytesReg  <= (rowBytes > BYTE_CNT_W'(ROW_BYTES)) ? BYTE_CNT_W'(ROW_BYTES) : rowBytes;
      countReg  <= countIn;
    end
  end

  for (genvar k = 0; k < ROW_BYTES; k++) begin : g_mask
    assign byteMask[8*k +: 8] = (BYTE_CNT_W'(k) < bytesReg) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) tile[r] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (strobe.clearUpper && (CNT_W'(r) >= countIn)) begin
          tile[r] <= '0;
        end else if (strobe.writeRow && (curRow == CNT_W'(r))) begin
          tile[r] <= memRspData & byteMask;
        end
      end
    end
  end

  assign memReqAddr  = firstAddr + (ADDR_W'(curRow) * strideReg);
  assign memReqBytes = bytesReg;
  assign readData    = (CNT_W'(readRow) < countReg) ? tile[readRow] : '0;

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeRow |-> (curRow < countReg)); // R9
  AST_STRIDE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCfg && !indexPresent) |=> (strideReg == '0)); // R4
  AST_BYTES_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    memReqBytes <= BYTE_CNT_W'(ROW_BYTES)); // R3

endmodule

// File: rtl/tile_row_loader.sv
module tile_row_loader
  import tile_loader_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 64,
  parameter int ADDR_W    = 32,
  localparam int CNT_W      = $clog2(ROWS + 1),
  localparam int ROW_W      = $clog2(ROWS),
  localparam int BYTE_CNT_W = $clog2(ROW_BYTES + 1),
  localparam int DATA_W     = ROW_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startValid,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [ADDR_W-1:0]     dispAddr,
  input  logic [ADDR_W-1:0]     indexVal,
  input  logic [1:0]            scaleSel,
  input  logic                  indexPresent,
  input  logic [CNT_W-1:0]      rowCount,
  input  logic [BYTE_CNT_W-1:0] rowBytes,
  input  logic [CNT_W-1:0]      savedRow,
  output logic                  busy,
  output logic                  done,
  output logic                  fault,
  output logic [CNT_W-1:0]      resumeRow,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [ADDR_W-1:0]     memReqAddr,
  output logic [BYTE_CNT_W-1:0] memReqBytes,
  input  logic                  memRspValid,
  input  logic                  memRspFault,
  input  logic [DATA_W-1:0]     memRspData,
  input  logic [ROW_W-1:0]      readRow,
  output logic [DATA_W-1:0]     readData
);

  loaderStrobe_t    strobe;
  logic [CNT_W-1:0] curRow;

  tile_loader_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .rowCount   (rowCount),
    .savedRow   (savedRow),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .memRspFault(memRspFault),
    .strobe     (strobe),
    .curRow     (curRow),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .resumeRow  (resumeRow),
    .memReqValid(memReqValid)
  );

  tile_loader_dp #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .curRow      (curRow),
    .baseAddr    (baseAddr),
    .dispAddr    (dispAddr),
    .indexVal    (indexVal),
    .scaleSel    (scaleSel),
    .indexPresent(indexPresent),
    .rowCount    (rowCount),
    .rowBytes    (rowBytes),
    .memRspData  (memRspData),
    .readRow     (readRow),
    .memReqAddr  (memReqAddr),
    .memReqBytes (memReqBytes),
    .readData    (readData)
  );

endmodule

// File: tb/tile_row_loader_bench.sv
`timescale 1ns/1ps
module tile_row_loader_bench;
  localparam int ROWS = 16;
  localparam int RB   = 64;
  localparam int AW   = 32;
  localparam int CW   = 5;
  localparam int BW   = 7;
  localparam int DW   = RB * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startValid = 1'b0;
  logic [AW-1:0] baseAddr = '0, dispAddr = '0, indexVal = '0;
  logic [1:0]    scaleSel = '0;
  logic          indexPresent = 1'b0;
  logic [CW-1:0] rowCount = '0, savedRow = '0;
  logic [BW-1:0] rowBytes = '0;
  logic          busy, done, fault, memReqValid;
  logic [CW-1:0] resumeRow;
  logic          memReqReady = 1'b0;
  logic [AW-1:0] memReqAddr;
  logic [BW-1:0] memReqBytes;
  logic          memRspValid = 1'b0, memRspFault = 1'b0;
  logic [DW-1:0] memRspData = '0;
  logic [3:0]    readRow = '0;
  logic [DW-1:0] readData;

  tile_row_loader u_tile_row_loader (
    .clk(clk), .rstN(rstN), .startValid(startValid), .baseAddr(baseAddr),
    .dispAddr(dispAddr), .indexVal(indexVal), .scaleSel(scaleSel),
    .indexPresent(indexPresent), .rowCount(rowCount), .rowBytes(rowBytes),
    .savedRow(savedRow), .busy(busy), .done(done), .fault(fault),
    .resumeRow(resumeRow), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqBytes(memReqBytes), .memRspValid(memRspValid),
    .memRspFault(memRspFault), .memRspData(memRspData), .readRow(readRow),
    .readData(readData)
  );

  always #5 clk = ~clk;

  int vecCnt = 0;
  int errCnt = 0;
  logic [AW-1:0] expAddrQ[$];
  int            expBytesQ[$];
  logic [DW-1:0] model [ROWS];
  int failReq = -1;
  int reqIdx = 0;
  int stallSet = 0;

  function automatic logic [DW-1:0] patRow(logic [AW-1:0] a, int nb);
    logic [DW-1:0] v = '0;
    for (int k = 0; k < RB; k++)
      if (k < nb) v[8*k +: 8] = 8'(a[7:0] ^ a[15:8]) + 8'(k * 7) + 8'h03;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory responder and request monitor (scoreboard pop side)
  initial begin
    bit            rspPend = 0;
    int            stallCnt = 0;
    logic [AW-1:0] lastAddr = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memReqReady = 1'b0;
      memRspFault = 1'b0;
      if (rspPend) begin
        memRspValid = 1'b1;
        memRspFault = ((reqIdx - 1) == failReq);
        memRspData  = patRow(lastAddr, RB);
        rspPend = 0;
      end else if (memReqValid) begin
        if (stallCnt < stallSet) begin
          stallCnt++;
        end else begin
          stallCnt = 0;
          memReqReady = 1'b1;
          if (expAddrQ.size() == 0) begin
            check(0, "R6", "unexpected request", DW'(memReqAddr), '0);
          end else begin
            logic [AW-1:0] ea;
            int eb;
            ea = expAddrQ.pop_front();
            eb = expBytesQ.pop_front();
            check(memReqAddr == ea, "R3", "request address", DW'(memReqAddr), DW'(ea));
            check(int'(memReqBytes) == eb, "R3", "request bytes", DW'(memReqBytes), DW'(eb));
          end
          lastAddr = memReqAddr;
          rspPend = 1;
          reqIdx++;
        end
      end
    end
  end

  // driver: pushes expected requests, runs one load, then checks the tile
  task automatic runJob(input logic [AW-1:0] b, input logic [AW-1:0] d,
                        input logic [AW-1:0] idx, input logic [1:0] sc, input bit pres,
                        input int cnt, input int nb, input int saved, input int failAt,
                        input bit midStart, input string tag, output int waitCyc);
    logic [AW-1:0] first, stride;
    int lastRow;
    first  = b + d;
    stride = pres ? (idx << sc) : '0;
    lastRow = (failAt >= 0) ? failAt : cnt - 1;
    for (int r = saved; r <= lastRow && r < cnt; r++) begin
      expAddrQ.push_back(first + AW'(r) * stride);
      expBytesQ.push_back(nb);
    end
    failReq = (failAt >= 0) ? (failAt - saved) : -1;
    reqIdx = 0;
    for (int r = cnt; r < ROWS; r++) model[r] = '0;
    for (int r = saved; r < cnt && (failAt < 0 || r < failAt); r++)
      model[r] = patRow(first + AW'(r) * stride, nb);

    @(negedge clk);
    startValid = 1'b1; baseAddr = b; dispAddr = d; indexVal = idx; scaleSel = sc;
    indexPresent = pres; rowCount = CW'(cnt); rowBytes = BW'(nb); savedRow = CW'(saved);
    @(negedge clk);
    startValid = 1'b0;
    if (midStart) begin
      @(negedge clk);
      check(busy == 1'b1, "R10", {tag, " busy before second start"}, DW'(busy), 1);
      startValid = 1'b1; baseAddr = 32'hDEAD0000; rowCount = 5'd2; savedRow = 5'd0;
      @(negedge clk);
      startValid = 1'b0;
    end
    waitCyc = 0;
    while (!(done || fault)) begin
      @(negedge clk);
      waitCyc++;
    end
    if (failAt < 0) begin
      check(done && !fault, "R7", {tag, " done pulse"}, DW'({done, fault}), DW'(2'b10));
      check(resumeRow == 0, "R7", {tag, " resume row"}, DW'(resumeRow), 0);
    end else begin
      check(fault && !done, "R8", {tag, " fault pulse"}, DW'({done, fault}), DW'(2'b01));
      check(int'(resumeRow) == failAt, "R8", {tag, " resume row"}, DW'(resumeRow), DW'(failAt));
    end
    check(busy == 1'b0, "R7", {tag, " busy low at end"}, DW'(busy), 0);
    check(expAddrQ.size() == 0, "R6", {tag, " all rows requested"}, DW'(expAddrQ.size()), 0);
    @(negedge clk);
    check(!done && !fault, "R7", {tag, " single cycle pulse"}, DW'({done, fault}), 0);
    repeat (3) @(negedge clk);
    check(memReqValid == 1'b0, "R8", {tag, " no request after end"}, DW'(memReqValid), 0);
    for (int r = 0; r < ROWS; r++) begin
      readRow = 4'(r);
      #1;
      check(readData == model[r], (r >= cnt) ? "R9" : "R5", {tag, " tile row"}, readData, model[r]);
    end
  endtask

  initial begin
    int cyc;
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busy && !done && !fault && !memReqValid, "R1", "reset outputs",
          DW'({busy, done, fault, memReqValid}), 0);
    check(resumeRow == 0, "R1", "reset resume row", DW'(resumeRow), 0);
    for (int r = 0; r < ROWS; r++) begin
      readRow = 4'(r);
      #1;
      check(readData == '0, "R1", "reset tile row", readData, '0);
    end

    // R3 R6: full tile, stalled request port
    stallSet = 2;
    runJob(32'h1000, 32'h20, 32'h40, 2'd2, 1'b1, 16, 64, 0, -1, 1'b0, "fullTile", cyc);
    stallSet = 0;
    // R5 R9: short rows, negative displacement, few rows
    runJob(32'h8000, 32'hFFFF_FFF0, 32'h3, 2'd3, 1'b1, 5, 10, 0, -1, 1'b0, "shortRows", cyc);
    // R4: no index register, stride zero
    runJob(32'h2345, 32'h11, 32'h55, 2'd1, 1'b0, 4, 64, 0, -1, 1'b0, "noIndex", cyc);
    // R8 R10: fault at row 3, with a start pulse while busy
    runJob(32'h4000, 32'h8, 32'h10, 2'd0, 1'b1, 8, 33, 0, 3, 1'b1, "faultRow3", cyc);
    // R2: restart from reported row
    runJob(32'h4000, 32'h8, 32'h10, 2'd0, 1'b1, 8, 33, 3, -1, 1'b0, "resume", cyc);
    // R11: start row already past the row count
    runJob(32'h6000, 32'h0, 32'h8, 2'd0, 1'b1, 4, 64, 6, -1, 1'b0, "emptyRange", cyc);
    check(cyc == 0, "R11", "done in cycle after start", DW'(cyc), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    #1_000_000;
    errCnt++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule